// File: doc/BRIEF.md
# Snooping Write-Through Cache with Posted Writes

This block is a direct-mapped, per-processor cache for a shared-bus multiprocessor. Every store the processor issues updates the local line when that line is held and is also queued for main memory, so memory never falls behind the cache. A small posted-write queue lets a store retire at once while the shared bus is busy. The processor waits only when the queue is full.

Other bus masters' writes are presented on a snoop input. A snooped write that lands in a line held locally invalidates that line, so the next local read fetches fresh data. Reads of shared data that nobody writes need no coherency traffic. An address window set by a base and a mask is never cached: reads there always go to the bus and never allocate a line.

A read that misses first looks in the posted-write queue. If the queue holds a store to the same word, the newest such store answers the read. If the queue holds a store to a different word of the same line, the miss waits until that store has drained, so the fill never brings a stale word into the cache.

Top module: `wt_snoop_cache`

## Requirements
- R1: After reset no line is valid, the posted-write queue is empty and `bus_req` is low. The first read of any address therefore misses.
- R2: A cacheable read miss issues one line read on the bus. `bus_req` is held until `bus_gnt`, and the line arrives on `bus_rvalid`, which is also the cycle `cpu_ready` rises. The line is then allocated, and a later read of either word in it completes in the same cycle it is presented, with no bus read.
- R3: Each accepted store appears exactly once on the bus as a word write (`bus_we`=1) with the same address and data. Stores reach the bus in the order they were accepted.
- R4: A store that hits a held line updates that word in the cache, so a later read returns the stored value without a bus read.
- R5: The posted-write queue holds `WB_DEPTH` stores (4 by default). While it is not full, a store is accepted (`cpu_ready`=1) in the cycle it is presented. While it is full, `cpu_ready` stays low until an entry has drained.
- R6: A snooped write (`snp_valid`=1) whose address lies in a held line invalidates that line, and the next read of it goes to the bus.
- R7: A snooped write to a line not held, including one with the same index and a different tag, leaves the held line valid, and reads of it still hit.
- R8: An address `a` with `((a ^ NC_BASE) & NC_MASK) == 0` is noncacheable. Every read of it issues a bus read, and it is never allocated.
- R9: A read miss to a word that has stores still waiting in the queue returns the newest such store's data in the same cycle, with no bus read.
- R10: When a snooped write hits the line being filled, in the same cycle as the fill, the line ends up invalid.
- R11: Address bits [6:3] (for 16 lines) select the line, and bit 2 selects the word: 0 gives `bus_rdata[31:0]`, 1 gives `bus_rdata[63:32]`. Line reads on the bus carry bits [2:0]=0, and word writes carry bits [1:0]=0.
- R12: A store that misses allocates no line. A later read of that address goes to the bus and returns the stored value.
- R13: A read miss to a line for which the queue holds a store to another word of that line waits, with `cpu_ready` low, until that store has drained. The fill then contains the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| bus_req | output | 1 | Bus transfer request, held until granted |
| bus_we | output | 1 | 1 = word write, 0 = line read |
| bus_addr | output | 32 | Transfer address |
| bus_wdata | output | 32 | Write data |
| bus_gnt | input | 1 | Grant; the transfer is taken this cycle |
| bus_rvalid | input | 1 | Line read data is present |
| bus_rdata | input | 64 | Line read data, low word at the lower address |
| snp_valid | input | 1 | Another master writes on the shared bus |
| snp_addr | input | 32 | Address of that foreign write |

## Verification
The bench targets four ordering hazards.

- **Full queue.** The bench fills the queue while the bus refuses grants. A design that ignores the full flag would overwrite the oldest store, and one written address would then be missing from the bus log.
- **Forwarding.** The bench makes two stores to one word and reads that word before either has drained. A design that does not forward would read memory, and one that forwards the oldest match would return the first value.
- **Same-line read behind a queued store.** The bench reads a neighbouring word while a store to the same line is stuck in the queue. An eager fill would later return stale data on a hit to the stored word.
- **Snoop during a fill.** The bench lands a snoop in the very cycle a fill is written. A design where the fill wins would keep the line, so the follow-up read would not reach the bus.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
   localparam int ADDR_W = 32;
   localparam int WORD_W = 32;
   localparam int LINE_W = 64;
   localparam int OFS_W  = 3;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_RD_REQ  = 2'd1,
      ST_RD_WAIT = 2'd2
   } rd_state_e;

   typedef struct packed {
      logic [ADDR_W-1:0] addr;
      logic [WORD_W-1:0] data;
   } wb_entry_t;
endpackage

// File: rtl/wtc_nc_window.sv
module wtc_nc_window
   import wtc_pkg::*;
#(
   parameter bit              EN   = 1'b1,
   parameter logic [ADDR_W-1:0] BASE = 32'hF000_0000,
   parameter logic [ADDR_W-1:0] MASK = 32'hF000_0000
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              is_nc
);
   generate
      if (EN) begin : g_window
         assign is_nc = (((addr ^ BASE) & MASK) == '0);
      end else begin : g_none
         logic unused_addr;
         assign unused_addr = ^addr;
         assign is_nc = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/wtc_post_buf.sv
module wtc_post_buf
   import wtc_pkg::*;
#(
   parameter int DEPTH = 4,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic [WORD_W-1:0] push_data,
   input  logic              pop,
   output logic [ADDR_W-1:0] head_addr,
   output logic [WORD_W-1:0] head_data,
   output logic [CNT_W-1:0]  count,
   output logic              full,
   output logic              empty,
   input  logic [ADDR_W-1:0] q_addr,
   output logic              fwd_word_hit,
   output logic              fwd_line_hit,
   output logic [WORD_W-1:0] fwd_data
);
   generate
      if (DEPTH < 1) begin : g_bad_depth
         initial $fatal(1, "wtc_post_buf: DEPTH must be at least 1");
      end
   endgenerate

   wb_entry_t           slot_q [DEPTH];
   logic [PTR_W-1:0]    rd_ptr_q, wr_ptr_q;
   logic [CNT_W-1:0]    cnt_q;

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr_q <= '0;
         wr_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (push) wr_ptr_q <= bump(wr_ptr_q);
         if (pop)  rd_ptr_q <= bump(rd_ptr_q);
         cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) slot_q[wr_ptr_q] <= '{addr: push_addr, data: push_data};
   end

   assign head_addr = slot_q[rd_ptr_q].addr;
   assign head_data = slot_q[rd_ptr_q].data;
   assign count     = cnt_q;
   assign full      = (cnt_q == CNT_W'(DEPTH));
   assign empty     = (cnt_q == '0);

   // Oldest to newest scan: the last match wins, so the newest store answers.
   always_comb begin
      logic [PTR_W:0] s;
      fwd_word_hit = 1'b0;
      fwd_line_hit = 1'b0;
      fwd_data     = '0;
      for (int i = 0; i < DEPTH; i++) begin
         s = {1'b0, rd_ptr_q} + (PTR_W+1)'(i);
         if (s >= (PTR_W+1)'(DEPTH)) s = s - (PTR_W+1)'(DEPTH);
         if (CNT_W'(i) < cnt_q) begin
            if (slot_q[s[PTR_W-1:0]].addr[ADDR_W-1:OFS_W] == q_addr[ADDR_W-1:OFS_W]) begin
               if (slot_q[s[PTR_W-1:0]].addr[OFS_W-1:2] == q_addr[OFS_W-1:2]) begin
                  fwd_word_hit = 1'b1;
                  fwd_data     = slot_q[s[PTR_W-1:0]].data;
               end else begin
                  fwd_line_hit = 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/wtc_tag_store.sv
module wtc_tag_store
   import wtc_pkg::*;
#(
   parameter int LINES = 16,
   localparam int IDX_W = $clog2(LINES),
   localparam int TAG_W = ADDR_W - OFS_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  lk_idx,
   input  logic [TAG_W-1:0]  lk_tag,
   output logic              lk_hit,
   output logic [LINE_W-1:0] lk_line,
   input  logic              fill_en,
   input  logic [IDX_W-1:0]  fill_idx,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [LINE_W-1:0] fill_line,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_hi,
   input  logic [WORD_W-1:0] wr_word,
   input  logic              snp_en,
   input  logic [IDX_W-1:0]  snp_idx,
   input  logic [TAG_W-1:0]  snp_tag,
   output logic [LINES-1:0]  valid_vec
);
   logic [LINES-1:0]  valid_q;
   logic [TAG_W-1:0]  tag_q [LINES];
   logic [LINE_W-1:0] dat_q [LINES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
      end else begin
         for (int i = 0; i < LINES; i++) begin
            if (fill_en && fill_idx == IDX_W'(i)) begin
               // A snoop naming the incoming line cancels the allocation.
               valid_q[i] <= !(snp_en && snp_idx == IDX_W'(i) && snp_tag == fill_tag);
               tag_q[i]   <= fill_tag;
            end else if (snp_en && snp_idx == IDX_W'(i) && valid_q[i] && tag_q[i] == snp_tag) begin
               valid_q[i] <= 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) begin
         dat_q[fill_idx] <= fill_line;
      end else if (wr_en) begin
         if (wr_hi) dat_q[wr_idx][LINE_W-1:WORD_W] <= wr_word;
         else       dat_q[wr_idx][WORD_W-1:0]      <= wr_word;
      end
   end

   assign lk_hit    = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
   assign lk_line   = dat_q[lk_idx];
   assign valid_vec = valid_q;
endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache
   import wtc_pkg::*;
#(
   parameter int                LINES    = 16,
   parameter int                WB_DEPTH = 4,
   parameter bit                NC_EN    = 1'b1,
   parameter logic [ADDR_W-1:0] NC_BASE  = 32'hF000_0000,
   parameter logic [ADDR_W-1:0] NC_MASK  = 32'hF000_0000,
   localparam int IDX_W = $clog2(LINES),
   localparam int TAG_W = ADDR_W - OFS_W - IDX_W,
   localparam int CNT_W = $clog2(WB_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [31:0]       cpu_addr,
   input  logic [31:0]       cpu_wdata,
   output logic              cpu_ready,
   output logic [31:0]       cpu_rdata,
   output logic              bus_req,
   output logic              bus_we,
   output logic [31:0]       bus_addr,
   output logic [31:0]       bus_wdata,
   input  logic              bus_gnt,
   input  logic              bus_rvalid,
   input  logic [63:0]       bus_rdata,
   input  logic              snp_valid,
   input  logic [31:0]       snp_addr
);
   generate
      if (LINES < 2 || (1 << IDX_W) != LINES) begin : g_bad_lines
         initial $fatal(1, "wt_snoop_cache: LINES must be a power of two, at least 2");
      end
      if (WB_DEPTH < 1) begin : g_bad_depth
         initial $fatal(1, "wt_snoop_cache: WB_DEPTH must be at least 1");
      end
   endgenerate

   // ---------------- address split ----------------
   logic [IDX_W-1:0] cpu_idx, snp_idx;
   logic [TAG_W-1:0] cpu_tag, snp_tag;
   logic             word_hi;
   logic             unused_bits;

   assign cpu_idx     = cpu_addr[OFS_W +: IDX_W];
   assign cpu_tag     = cpu_addr[ADDR_W-1 -: TAG_W];
   assign snp_idx     = snp_addr[OFS_W +: IDX_W];
   assign snp_tag     = snp_addr[ADDR_W-1 -: TAG_W];
   assign word_hi     = cpu_addr[2];
   assign unused_bits = ^{cpu_addr[1:0], snp_addr[OFS_W-1:0]};

   // ---------------- sub-blocks ----------------
   logic              is_nc;
   logic              lk_hit;
   logic [LINE_W-1:0] lk_line;
   logic [LINES-1:0]  valid_vec;
   logic              fill_en, wr_hit_en;

   logic              wb_push, wb_pop, wb_full, wb_empty;
   logic [CNT_W-1:0]  wb_count;
   logic [ADDR_W-1:0] wb_head_addr;
   logic [WORD_W-1:0] wb_head_data;
   logic              fwd_word_hit, fwd_line_hit;
   logic [WORD_W-1:0] fwd_data;

   wtc_nc_window #(.EN(NC_EN), .BASE(NC_BASE), .MASK(NC_MASK)) u_ncw (
      .addr  (cpu_addr),
      .is_nc (is_nc)
   );

   wtc_tag_store #(.LINES(LINES)) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_idx    (cpu_idx),
      .lk_tag    (cpu_tag),
      .lk_hit    (lk_hit),
      .lk_line   (lk_line),
      .fill_en   (fill_en),
      .fill_idx  (cpu_idx),
      .fill_tag  (cpu_tag),
      .fill_line (bus_rdata),
      .wr_en     (wr_hit_en),
      .wr_idx    (cpu_idx),
      .wr_hi     (word_hi),
      .wr_word   (cpu_wdata),
      .snp_en    (snp_valid),
      .snp_idx   (snp_idx),
      .snp_tag   (snp_tag),
      .valid_vec (valid_vec)
   );

   wtc_post_buf #(.DEPTH(WB_DEPTH)) u_wbuf (
      .clk          (clk),
      .rst_n        (rst_n),
      .push         (wb_push),
      .push_addr    (cpu_addr),
      .push_data    (cpu_wdata),
      .pop          (wb_pop),
      .head_addr    (wb_head_addr),
      .head_data    (wb_head_data),
      .count        (wb_count),
      .full         (wb_full),
      .empty        (wb_empty),
      .q_addr       (cpu_addr),
      .fwd_word_hit (fwd_word_hit),
      .fwd_line_hit (fwd_line_hit),
      .fwd_data     (fwd_data)
   );

   // ---------------- access control ----------------
   rd_state_e st_q, st_d;
   logic      hit, idle, wr_acc, rd_hit, rd_fwd, rd_miss;

   assign hit     = lk_hit && !is_nc;
   assign idle    = (st_q == ST_IDLE);
   assign wr_acc  = idle && cpu_req && cpu_we && !wb_full;
   assign rd_hit  = idle && cpu_req && !cpu_we && hit;
   assign rd_fwd  = idle && cpu_req && !cpu_we && !hit && fwd_word_hit;
   // A miss is held back while a store to a sibling word is still queued.
   assign rd_miss = idle && cpu_req && !cpu_we && !hit && !fwd_word_hit && !fwd_line_hit;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:    if (rd_miss)    st_d = ST_RD_REQ;
         ST_RD_REQ:  if (bus_gnt)    st_d = ST_RD_WAIT;
         ST_RD_WAIT: if (bus_rvalid) st_d = ST_IDLE;
         default:                    st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign wb_push   = wr_acc;
   assign wr_hit_en = wr_acc && hit;
   assign fill_en   = (st_q == ST_RD_WAIT) && bus_rvalid && !is_nc;

   // ---------------- processor return ----------------
   always_comb begin
      cpu_ready = 1'b0;
      cpu_rdata = '0;
      if (st_q == ST_RD_WAIT) begin
         cpu_ready = bus_rvalid;
         cpu_rdata = word_hi ? bus_rdata[LINE_W-1:WORD_W] : bus_rdata[WORD_W-1:0];
      end else if (idle) begin
         cpu_ready = wr_acc || rd_hit || rd_fwd;
         if (rd_fwd)      cpu_rdata = fwd_data;
         else if (rd_hit) cpu_rdata = word_hi ? lk_line[LINE_W-1:WORD_W] : lk_line[WORD_W-1:0];
      end
   end

   // ---------------- bus side ----------------
   always_comb begin
      bus_req   = 1'b0;
      bus_we    = 1'b1;
      bus_addr  = {wb_head_addr[ADDR_W-1:2], 2'b00};
      bus_wdata = wb_head_data;
      unique case (st_q)
         ST_IDLE:   bus_req = !wb_empty;
         ST_RD_REQ: begin
            bus_req  = 1'b1;
            bus_we   = 1'b0;
            bus_addr = {cpu_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
         end
         default:   bus_req = 1'b0;
      endcase
   end

   assign wb_pop = idle && !wb_empty && bus_gnt;
endmodule

// File: rtl/wt_snoop_cache_chk.sv
module wt_snoop_cache_chk #(
   parameter int LINES = 16,
   parameter int DEPTH = 4,
   localparam int IDX_W = $clog2(LINES),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cpu_req,
   input logic             cpu_we,
   input logic             cpu_ready,
   input logic [31:3]      cpu_line,
   input logic             bus_req,
   input logic             bus_we,
   input logic             bus_gnt,
   input logic [2:0]       bus_lo,
   input logic             snp_valid,
   input logic [31:3]      snp_line,
   input logic [CNT_W-1:0] wb_count,
   input logic             wb_full,
   input logic             fill_en,
   input logic             is_nc,
   input logic [LINES-1:0] valid_vec
);
   logic [IDX_W-1:0] idx_d;
   always_ff @(posedge clk) idx_d <= cpu_line[IDX_W+2:3];

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      wb_count <= CNT_W'(DEPTH));                                               // R5
   AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_we && wb_full) |-> !cpu_ready);                           // R5
   AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> cpu_req);                                                   // R2
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_gnt) |=> bus_req);                                       // R3
   AST_LINE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we) |-> (bus_lo == 3'b000));                             // R11
   AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we) |-> (bus_lo[1:0] == 2'b00));                          // R11
   AST_NC_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |-> !is_nc);                                                      // R8
   AST_FILL_SNOOP_KILL: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && snp_valid && snp_line == cpu_line) |=> !valid_vec[idx_d]);    // R10
endmodule

bind wt_snoop_cache wt_snoop_cache_chk #(.LINES(LINES), .DEPTH(WB_DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_req   (cpu_req),
   .cpu_we    (cpu_we),
   .cpu_ready (cpu_ready),
   .cpu_line  (cpu_addr[31:3]),
   .bus_req   (bus_req),
   .bus_we    (bus_we),
   .bus_gnt   (bus_gnt),
   .bus_lo    (bus_addr[2:0]),
   .snp_valid (snp_valid),
   .snp_line  (snp_addr[31:3]),
   .wb_count  (wb_count),
   .wb_full   (wb_full),
   .fill_en   (fill_en),
   .is_nc     (is_nc),
   .valid_vec (valid_vec)
);

// File: tb/sim_wt_snoop_cache.sv
module sim_wt_snoop_cache;
   localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_SN = 2'd2;

   typedef struct packed {
      logic [1:0]  op;
      logic [31:0] addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic [3:0]  rd_delta;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VT [NV] = '{
      '{OP_RD, 32'h0000_0100, 32'h0,         32'hC0DE_0100, 4'd1, 8'd1},  // R1 first read misses
      '{OP_RD, 32'h0000_0104, 32'h0,         32'hC0DE_0104, 4'd0, 8'd11}, // R11 upper word, R2 hit
      '{OP_WR, 32'h0000_0104, 32'hAAAA_5555, 32'h0,         4'd0, 8'd3},  // R3
      '{OP_RD, 32'h0000_0104, 32'h0,         32'hAAAA_5555, 4'd0, 8'd4},  // R4
      '{OP_SN, 32'h0000_0180, 32'h0,         32'h0,         4'd0, 8'd7},  // R7 same index other tag
      '{OP_RD, 32'h0000_0100, 32'h0,         32'hC0DE_0100, 4'd0, 8'd7},  // R7 still a hit
      '{OP_SN, 32'h0000_0104, 32'h0,         32'h0,         4'd0, 8'd6},  // R6
      '{OP_RD, 32'h0000_0100, 32'h0,         32'hC0DE_0100, 4'd1, 8'd6},  // R6 refetch
      '{OP_RD, 32'hF000_0010, 32'h0,         32'hC0DE_0010, 4'd1, 8'd8},  // R8
      '{OP_RD, 32'hF000_0010, 32'h0,         32'hC0DE_0010, 4'd1, 8'd8},  // R8 never cached
      '{OP_RD, 32'h0000_0104, 32'h0,         32'hAAAA_5555, 4'd0, 8'd2}   // R2 R3 memory took the store
   };

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic        cpu_ready;
   logic [31:0] cpu_rdata;
   logic        bus_req, bus_we;
   logic [31:0] bus_addr, bus_wdata;
   logic        bus_gnt = 1'b0, bus_rvalid = 1'b0;
   logic [63:0] bus_rdata = '0;
   logic        snp_valid = 1'b0;
   logic [31:0] snp_addr = '0;

   always #10 clk = ~clk;

   wt_snoop_cache u0 (.*);

   int n_chk = 0, n_fail = 0;
   int rd_count = 0, align_err = 0, wn = 0;
   logic [31:0] mem [1024];
   logic [31:0] wlog_a [32], wlog_d [32];
   bit          stall_bus = 1'b0, snoop_on_fill = 1'b0, snp_pulse = 1'b0, rd_pend = 1'b0;
   logic [31:0] snp_pulse_addr = '0, rd_addr = '0;

   // Memory and shared-bus model: every input change happens at a falling edge.
   always @(negedge clk) begin
      bus_gnt    = 1'b0;
      bus_rvalid = 1'b0;
      snp_valid  = 1'b0;
      if (snp_pulse) begin
         snp_valid = 1'b1;
         snp_addr  = snp_pulse_addr;
         snp_pulse = 1'b0;
      end
      if (rd_pend) begin
         bus_rvalid = 1'b1;
         bus_rdata  = {mem[{rd_addr[11:3], 1'b1}], mem[{rd_addr[11:3], 1'b0}]};
         rd_count++;
         rd_pend = 1'b0;
         if (snoop_on_fill) begin
            snp_valid = 1'b1;
            snp_addr  = rd_addr;
         end
      end else if (bus_req === 1'b1 && !stall_bus) begin
         bus_gnt = 1'b1;
         if (bus_we) begin
            if (bus_addr[1:0] != 2'b00) align_err++;
            mem[bus_addr[11:2]] = bus_wdata;
            wlog_a[wn % 32] = bus_addr;
            wlog_d[wn % 32] = bus_wdata;
            wn++;
         end else begin
            if (bus_addr[2:0] != 3'b000) align_err++;
            rd_pend = 1'b1;
            rd_addr = bus_addr;
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic start_req(input bit we, input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
   endtask

   task automatic wait_ready(input int maxc, output bit ok, output logic [31:0] rd);
      ok = 1'b0; rd = '0;
      for (int c = 0; c < maxc && !ok; c++) begin
         #5;
         if (cpu_ready === 1'b1) begin
            ok = 1'b1;
            rd = cpu_rdata;
         end
         @(negedge clk);
      end
   endtask

   task automatic end_req();
      cpu_req = 1'b0; cpu_we = 1'b0;
   endtask

   task automatic do_op(input bit we, input logic [31:0] a, input logic [31:0] d,
                        input int maxc, output bit ok, output logic [31:0] rd);
      start_req(we, a, d);
      wait_ready(maxc, ok, rd);
      end_req();
   endtask

   task automatic snoop(input logic [31:0] a);
      @(negedge clk);
      snp_pulse_addr = a;
      snp_pulse      = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      bit          ok;
      logic [31:0] rd;
      int          rd0, w0;
      for (int i = 0; i < 1024; i++) mem[i] = 32'hC0DE_0000 | (i << 2);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #5;
      chk("R1 ready idle after reset", {31'b0, cpu_ready}, 32'd0);
      chk("R1 no bus request after reset", {31'b0, bus_req}, 32'd0);

      // Vector table
      for (int k = 0; k < NV; k++) begin
         rd0 = rd_count;
         if (VT[k].op == OP_SN) begin
            snoop(VT[k].addr);
         end else begin
            do_op(VT[k].op == OP_WR, VT[k].addr, VT[k].data, 40, ok, rd);
            chk($sformatf("R%0d vec %0d completes", VT[k].req, k), {31'b0, ok}, 32'd1);
            if (VT[k].op == OP_RD)
               chk($sformatf("R%0d vec %0d data", VT[k].req, k), rd, VT[k].exp);
         end
         chk($sformatf("R%0d vec %0d bus reads", VT[k].req, k), 32'(rd_count - rd0), 32'(VT[k].rd_delta));
         repeat (4) @(negedge clk);
      end

      // R5 and R3: fill the queue while the bus refuses grants
      stall_bus = 1'b1;
      w0 = wn;
      for (int i = 0; i < 4; i++) begin
         do_op(1'b1, 32'h200 + 32'(i * 4), 32'h5000_0000 + 32'(i), 1, ok, rd);
         chk("R5 store accepted at once", {31'b0, ok}, 32'd1);
      end
      start_req(1'b1, 32'h210, 32'h5000_0004);
      wait_ready(4, ok, rd);
      chk("R5 full queue stalls", {31'b0, ok}, 32'd0);
      stall_bus = 1'b0;
      wait_ready(10, ok, rd);
      end_req();
      chk("R5 store accepted after drain", {31'b0, ok}, 32'd1);
      repeat (12) @(negedge clk);
      chk("R3 five bus writes", 32'(wn - w0), 32'd5);
      for (int i = 0; i < 5; i++) begin
         chk("R3 write order addr", wlog_a[(w0 + i) % 32], 32'h200 + 32'(i * 4));
         chk("R3 write order data", wlog_d[(w0 + i) % 32], 32'h5000_0000 + 32'(i));
      end

      // R9: newest queued store answers a read miss
      stall_bus = 1'b1;
      do_op(1'b1, 32'h300, 32'h1111_1111, 1, ok, rd);
      do_op(1'b1, 32'h300, 32'h2222_2222, 1, ok, rd);
      rd0 = rd_count;
      do_op(1'b0, 32'h300, 32'h0, 1, ok, rd);
      chk("R9 forwarded in one cycle", {31'b0, ok}, 32'd1);
      chk("R9 newest data", rd, 32'h2222_2222);
      chk("R9 no bus read", 32'(rd_count - rd0), 32'd0);
      stall_bus = 1'b0;
      repeat (10) @(negedge clk);

      // R12: stores do not allocate
      rd0 = rd_count;
      do_op(1'b0, 32'h300, 32'h0, 40, ok, rd);
      chk("R12 read after store goes to bus", 32'(rd_count - rd0), 32'd1);
      chk("R12 data from memory", rd, 32'h2222_2222);
      rd0 = rd_count;
      do_op(1'b0, 32'h300, 32'h0, 40, ok, rd);
      chk("R2 second read hits", 32'(rd_count - rd0), 32'd0);

      // R13: miss waits for a queued store to a sibling word
      stall_bus = 1'b1;
      do_op(1'b1, 32'h600, 32'hBEEF_0001, 1, ok, rd);
      start_req(1'b0, 32'h604, 32'h0);
      wait_ready(5, ok, rd);
      chk("R13 miss held while sibling queued", {31'b0, ok}, 32'd0);
      stall_bus = 1'b0;
      wait_ready(30, ok, rd);
      end_req();
      chk("R13 miss completes", {31'b0, ok}, 32'd1);
      chk("R13 miss data", rd, 32'hC0DE_0604);
      rd0 = rd_count;
      do_op(1'b0, 32'h600, 32'h0, 40, ok, rd);
      chk("R13 fill holds drained store", rd, 32'hBEEF_0001);
      chk("R13 sibling word hits", 32'(rd_count - rd0), 32'd0);

      // R10: snoop in the fill cycle leaves the line invalid
      snoop_on_fill = 1'b1;
      rd0 = rd_count;
      do_op(1'b0, 32'h700, 32'h0, 40, ok, rd);
      snoop_on_fill = 1'b0;
      chk("R10 fill data", rd, 32'hC0DE_0700);
      repeat (2) @(negedge clk);
      do_op(1'b0, 32'h700, 32'h0, 40, ok, rd);
      chk("R10 line invalid after race", 32'(rd_count - rd0), 32'd2);

      chk("R11 bus address alignment", 32'(align_err), 32'd0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule